// File: doc/BRIEF.md
# Multi-Channel DMA Bus Arbiter

This block chooses, one bus unit at a time, which of four DMA channels or the CPU drives a shared bus. Each channel brings a synchronised level request and a mode bit that selects burst or cycle-steal operation. It also has a 16-bit transfer counter, which software-side logic preloads through a load strobe. The arbiter issues exactly one grant per unit, one-hot across the four channel grants and the CPU grant. It decrements the counter of the channel that used the unit, and it stops granting a channel whose counter has reached zero.

The channels are ranked in a fixed order. A burst channel keeps the bus from one unit to the next. A cycle-steal channel gives the bus up after every unit. A higher-ranked channel takes over at the next unit boundary even when a lower-ranked burst is still running. When the higher-ranked channel is itself in burst mode, it runs to completion before the interrupted burst resumes. When it is in cycle-steal mode, the two channels trade units one for one. The CPU is kept off the bus for as long as any burst channel still has work. It gets the bus whenever no channel is eligible, and a lone cycle-steal channel hands it every other unit.

Each grant is registered. Inputs present before a clock edge set the grant that is active for the whole following clock, which models one bus unit.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is low at a clock edge, the CPU grant is set, all channel grants are clear, unit_done is low and every remaining count reads zero.
- R2: In every cycle after reset, exactly one of grant_chan[3:0] and grant_cpu is high.
- R3: A channel is eligible when its request is high and its count is non-zero. Among eligible channels, the grant for the next unit goes by the fixed rank channel 0, then 3, then 2, then 1. A channel whose request is low is never granted in the following unit.
- R4: An eligible burst channel (mode bit 1) is granted on consecutive units until a higher-ranked channel is eligible, its count reaches zero or its request drops. A higher-ranked burst channel that takes over keeps the bus until it is done, and then the interrupted burst resumes.
- R5: A cycle-steal channel (mode bit 0) is never granted on two consecutive units. When a lower-ranked burst channel is eligible, the two alternate unit by unit.
- R6: The CPU is never granted in the unit after a cycle in which any burst channel is eligible.
- R7: A load strobe writes cnt_load_val into the channel's counter. Each granted unit decrements that channel's count by one. A channel with a zero count is not granted.
- R8: With no eligible candidate, the CPU is granted. A single cycle-steal channel with no burst activity therefore gets every other unit, and the CPU gets the units in between.
- R9: unit_done is high exactly in the cycles where some channel grant is high.
- R10: The remaining output carries channel i's count in bits [16*i+15 : 16*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one bus unit |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_req | input | 4 | Per-channel transfer request, level |
| chan_burst | input | 4 | Per-channel mode: 1 burst, 0 cycle-steal |
| cnt_load | input | 4 | Per-channel counter load strobe |
| cnt_load_val | input | 16 | Count written by a load strobe |
| grant_chan | output | 4 | One-hot channel grant for the current unit |
| grant_cpu | output | 1 | CPU grant for the current unit |
| unit_done | output | 1 | Strobe: a channel unit completes this cycle |
| remaining | output | 64 | Packed remaining counts, channel i at [16*i +: 16] |

## Verification
Two functions can land on the same unit boundary. The first is a cycle-steal channel giving the bus up. The second is a lower-ranked burst channel claiming the bus, or being kept off it by the cycle-steal channel. The bench provokes this by raising a cycle-steal request in the middle of a running burst. It then checks the whole interleaved grant sequence against a hand-built expectation, including the absence of any CPU unit. A second case lets a channel's last count unit coincide with a hand-over to the next-ranked channel. It is judged by the exact grant order and by the remaining counts once the sequence has drained.

// File: rtl/dma_arb_pkg.sv
// Package: shared constants, types and the fixed channel ranking used by the
// DMA bus arbiter. Assumes exactly four channels; the ranking is not numeric.
package dma_arb_pkg;

    localparam int NUM_CH   = 4;
    localparam int CH_IDX_W = $clog2(NUM_CH);

    typedef logic [CH_IDX_W-1:0] ch_idx_t;

    // One grant vector: CPU bit above the channel bits, one-hot overall.
    typedef struct packed {
        logic              cpu;
        logic [NUM_CH-1:0] chan;
    } grant_t;

    // Maps a rank position (0 = most urgent) to a channel index.
    function automatic ch_idx_t rank_to_chan(input int rank);
        case (rank)
            0:       return ch_idx_t'(0);
            1:       return ch_idx_t'(3);
            2:       return ch_idx_t'(2);
            default: return ch_idx_t'(1);
        endcase
    endfunction

endpackage

// File: rtl/dma_unit_counter.sv
// Module: per-channel remaining-unit counter. It loads on a strobe and steps
// down by one for each granted unit. It reports whether work remains after the
// current cycle's update. Assumes a load and a grant may coincide; the load wins.
module dma_unit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             unit_grant,
    output logic [CNT_W-1:0] cnt_q,
    output logic             has_work
);

    logic [CNT_W-1:0] cnt_nxt;

    // Next count: a load overrides, otherwise a granted unit consumes one.
    always_comb begin
        if (load)
            cnt_nxt = load_val;
        else if (unit_grant && (cnt_q != '0))
            cnt_nxt = cnt_q - 1'b1;
        else
            cnt_nxt = cnt_q;
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt;
    end

    // Work remains for the next unit only if the updated count is non-zero.
    always_comb has_work = (cnt_nxt != '0);

    // R7: a granted unit takes exactly one off the count.
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_grant && !load && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7: with no load and no grant the count holds.
    a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_grant && !load) |=> $stable(cnt_q));

    // R7: a load strobe writes the given value.
    a_r7_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/dma_candidate_filter.sv
// Module: works out which channels may compete for the next unit. A channel is
// eligible when it requests and has work left. A cycle-steal channel that holds
// the current unit is held out for one unit. Also flags any eligible burst
// channel, which locks the CPU out.
module dma_candidate_filter
    import dma_arb_pkg::*;
(
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] burst,
    input  logic [NUM_CH-1:0] has_work,
    input  logic [NUM_CH-1:0] cur_grant,
    output logic [NUM_CH-1:0] cand,
    output logic              burst_busy
);

    logic [NUM_CH-1:0] eligible;
    logic [NUM_CH-1:0] steal_hold;

    // Eligibility: a live request with units still to move.
    always_comb eligible = req & has_work;

    // Cycle-steal channels that just used the bus must yield for one unit.
    always_comb steal_hold = cur_grant & ~burst;

    // Candidate set for the next unit.
    always_comb cand = eligible & ~steal_hold;

    // Any eligible burst channel keeps the CPU off the bus.
    always_comb burst_busy = |(eligible & burst);

endmodule

// File: rtl/dma_rank_select.sv
// Module: fixed-rank selector. It picks the most urgent candidate channel in the
// package's ranking and falls back to the CPU when no candidate exists. Purely
// combinational; the output is always one-hot.
module dma_rank_select
    import dma_arb_pkg::*;
(
    input  logic [NUM_CH-1:0] cand,
    output grant_t            pick
);

    // Walk ranks from most urgent; the first candidate found wins.
    always_comb begin
        logic found;
        pick  = '0;
        found = 1'b0;
        for (int r = 0; r < NUM_CH; r++) begin
            if (!found && cand[rank_to_chan(r)]) begin
                pick.chan[rank_to_chan(r)] = 1'b1;
                found = 1'b1;
            end
        end
        if (!found)
            pick.cpu = 1'b1;
    end

endmodule

// File: rtl/dma_bus_arbiter.sv
// Module: top of the DMA bus arbiter. It registers one one-hot grant per clock
// (one bus unit) across four channels and the CPU. It keeps a count per channel
// and applies burst hold, cycle-steal yield and fixed-rank pre-emption.
// Assumes requests are already synchronised levels and that each grant lasts
// exactly one clock.
module dma_bus_arbiter
    import dma_arb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       chan_req,
    input  logic [NUM_CH-1:0]       chan_burst,
    input  logic [NUM_CH-1:0]       cnt_load,
    input  logic [CNT_W-1:0]        cnt_load_val,
    output logic [NUM_CH-1:0]       grant_chan,
    output logic                    grant_cpu,
    output logic                    unit_done,
    output logic [NUM_CH*CNT_W-1:0] remaining
);

    localparam int REM_W = NUM_CH * CNT_W;

    grant_t            grant_q;
    grant_t            grant_nxt;
    logic [NUM_CH-1:0] has_work;
    logic [NUM_CH-1:0] cand;
    logic              burst_busy;
    logic [REM_W-1:0]  rem_flat;

    // One counter per channel, packed into the remaining output.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_cnt
        dma_unit_counter #(
            .CNT_W (CNT_W)
        ) i_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (cnt_load[i]),
            .load_val   (cnt_load_val),
            .unit_grant (grant_q.chan[i]),
            .cnt_q      (rem_flat[i*CNT_W +: CNT_W]),
            .has_work   (has_work[i])
        );
    end

    dma_candidate_filter i_filter (
        .req        (chan_req),
        .burst      (chan_burst),
        .has_work   (has_work),
        .cur_grant  (grant_q.chan),
        .cand       (cand),
        .burst_busy (burst_busy)
    );

    dma_rank_select i_select (
        .cand (cand),
        .pick (grant_nxt)
    );

    // Grant register: the CPU owns the bus out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grant_q <= '{cpu: 1'b1, chan: '0};
        else
            grant_q <= grant_nxt;
    end

    // Drive the outputs from the registered grant and the counters.
    always_comb begin
        grant_chan = grant_q.chan;
        grant_cpu  = grant_q.cpu;
        unit_done  = |grant_q.chan;
        remaining  = rem_flat;
    end

    // R2: exactly one bus owner per unit.
    a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({grant_chan, grant_cpu}));

    // R6: an eligible burst channel keeps the CPU off the next unit.
    a_r6_cpu_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
        burst_busy |=> !grant_cpu);

    // R8: no requests at all hands the next unit to the CPU.
    a_r8_cpu_default: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req == '0) |=> grant_cpu);

    // R9: the unit strobe never accompanies a CPU unit.
    a_r9_done_not_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        unit_done |-> !grant_cpu);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R5: a cycle-steal channel yields after each unit.
        a_r5_steal_yields: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_chan[i] && !chan_burst[i]) |=> !grant_chan[i]);

        // R3: a channel without a request gets no grant in the next unit.
        a_r3_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_req[i] |=> !grant_chan[i]);
    end

endmodule

// File: tb/test_dma_bus_arbiter.sv
// Bench: a scoreboard for the DMA bus arbiter. Driver tasks apply the inputs at
// the falling edge and push the grant expected after the next rising edge. A
// monitor pops and compares each one 3 ns after that rising edge.
module test_dma_bus_arbiter;

    localparam int CNT_W = 16;
    localparam logic [4:0] G_CPU = 5'b10000;
    localparam logic [4:0] G_C0  = 5'b00001;
    localparam logic [4:0] G_C1  = 5'b00010;
    localparam logic [4:0] G_C2  = 5'b00100;
    localparam logic [4:0] G_C3  = 5'b01000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       chan_req = '0;
    logic [3:0]       chan_burst = '0;
    logic [3:0]       cnt_load = '0;
    logic [CNT_W-1:0] cnt_load_val = '0;
    logic [3:0]       grant_chan;
    logic             grant_cpu;
    logic             unit_done;
    logic [4*CNT_W-1:0] remaining;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    dma_bus_arbiter #(.CNT_W(CNT_W)) i_dma_bus_arbiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_req     (chan_req),
        .chan_burst   (chan_burst),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .grant_chan   (grant_chan),
        .grant_cpu    (grant_cpu),
        .unit_done    (unit_done),
        .remaining    (remaining)
    );

    task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Driver: one unit of stimulus plus the grant it should produce.
    task automatic unit(input logic [3:0] req, input logic [3:0] mode,
                        input logic [4:0] expg, input string tag);
        @(negedge clk);
        cnt_load   = '0;
        chan_req   = req;
        chan_burst = mode;
        exp_q.push_back(expg);
        tag_q.push_back(tag);
    endtask

    // Driver: preload one counter with requests idle; the CPU keeps the bus (R7, R8).
    task automatic load(input int ch, input logic [CNT_W-1:0] val);
        @(negedge clk);
        chan_req     = '0;
        cnt_load     = 4'(1 << ch);
        cnt_load_val = val;
        exp_q.push_back(G_CPU);
        tag_q.push_back("R8 load idle");
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        #1;
    endtask

    // Monitor: compare grant and unit strobe with the scoreboard head (R2, R9).
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() > 0) begin
                logic [4:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_val({t, " grant"}, {27'd0, grant_cpu, grant_chan}, {27'd0, e});
                check_val("R9 unit_done", {31'd0, unit_done}, {31'd0, |grant_chan});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check_val("R1 cpu grant", {31'd0, grant_cpu}, 32'd1);
        check_val("R1 chan grant", {28'd0, grant_chan}, 32'd0);
        check_val("R1 remaining lo", remaining[31:0], 32'd0);
        check_val("R1 remaining hi", remaining[63:32], 32'd0);
        rst_n = 1'b1;

        // R8: nothing requested, the CPU keeps the bus.
        unit(4'b0000, 4'b0000, G_CPU, "R8 idle");
        unit(4'b0000, 4'b1111, G_CPU, "R8 idle");

        // R4/R7: lone burst on channel 1 with three units, then it stops at zero.
        load(1, 16'd3);
        repeat (3) unit(4'b0010, 4'b0010, G_C1, "R4 burst hold");
        unit(4'b0010, 4'b0010, G_CPU, "R7 zero count");
        drain();
        check_val("R10 ch1 remaining", {16'd0, remaining[31:16]}, 32'd0);

        // R8/R5: a lone cycle-steal channel 2 interleaves with the CPU.
        load(2, 16'd3);
        unit(4'b0100, 4'b0000, G_C2,  "R8 steal");
        unit(4'b0100, 4'b0000, G_CPU, "R8 cpu gap");
        unit(4'b0100, 4'b0000, G_C2,  "R8 steal");
        unit(4'b0100, 4'b0000, G_CPU, "R8 cpu gap");
        unit(4'b0100, 4'b0000, G_C2,  "R8 steal");
        unit(4'b0100, 4'b0000, G_CPU, "R7 zero count");
        unit(4'b0100, 4'b0000, G_CPU, "R7 zero count");

        // R3/R7: dropping the request ends a burst and leaves the count.
        load(1, 16'd5);
        unit(4'b0010, 4'b0010, G_C1,  "R4 burst");
        unit(4'b0010, 4'b0010, G_C1,  "R4 burst");
        unit(4'b0000, 4'b0010, G_CPU, "R3 request dropped");
        drain();
        check_val("R7 ch1 after two units", {16'd0, remaining[31:16]}, 32'd3);

        // R5/R6: channel 2 cycle-steal interleaves with the channel 1 burst.
        load(1, 16'd10);
        load(2, 16'd3);
        unit(4'b0010, 4'b0010, G_C1, "R4 burst");
        unit(4'b0010, 4'b0010, G_C1, "R4 burst");
        unit(4'b0110, 4'b0010, G_C2, "R5 pre-empt");
        unit(4'b0110, 4'b0010, G_C1, "R6 no cpu");
        unit(4'b0110, 4'b0010, G_C2, "R5 alternate");
        unit(4'b0110, 4'b0010, G_C1, "R6 no cpu");
        unit(4'b0110, 4'b0010, G_C2, "R5 alternate");
        unit(4'b0110, 4'b0010, G_C1, "R6 no cpu");
        for (int k = 0; k < 5; k++)
            unit(4'b0110, 4'b0010, G_C1, "R4 burst resumes");
        unit(4'b0110, 4'b0010, G_CPU, "R7 both done");
        drain();
        check_val("R10 ch1 remaining", {16'd0, remaining[31:16]}, 32'd0);
        check_val("R10 ch2 remaining", {16'd0, remaining[47:32]}, 32'd0);

        // R4: a channel 3 burst pre-empts channel 1 and runs to completion.
        load(1, 16'd4);
        load(3, 16'd2);
        unit(4'b0010, 4'b1010, G_C1,  "R4 burst");
        unit(4'b1010, 4'b1010, G_C3,  "R4 burst pre-empt");
        unit(4'b1010, 4'b1010, G_C3,  "R4 pre-empter holds");
        unit(4'b1010, 4'b1010, G_C1,  "R4 resume");
        unit(4'b1010, 4'b1010, G_C1,  "R4 resume");
        unit(4'b1010, 4'b1010, G_C1,  "R4 resume");
        unit(4'b1010, 4'b1010, G_CPU, "R7 both done");

        // R3: rank order 0, 3, 2, 1 with one unit each.
        load(0, 16'd1);
        load(1, 16'd1);
        load(2, 16'd1);
        load(3, 16'd1);
        unit(4'b1111, 4'b1011, G_C0,  "R3 rank first");
        unit(4'b1111, 4'b1011, G_C3,  "R3 rank second");
        unit(4'b1111, 4'b1011, G_C2,  "R3 rank third");
        unit(4'b1111, 4'b1011, G_C1,  "R3 rank fourth");
        unit(4'b1111, 4'b1011, G_CPU, "R7 all done");
        drain();
        check_val("R10 all remaining lo", remaining[31:0], 32'd0);
        check_val("R10 all remaining hi", remaining[63:32], 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule